// File: doc/BRIEF.md
# Accumulator Logic and Byte-Move Unit

This block executes one group of accumulator instructions for a 16-bit processor. Each cycle in which `in_valid` is high, it takes a 4-bit sub-opcode, an accumulator select, a data-memory operand and that operand's word address. It then performs one of the following on the selected accumulator:

- a bitwise OR, AND or XOR with the operand;
- a byte load that clears the upper half of the accumulator;
- a byte store that writes one half of a memory word;
- a compare that only updates the flags.

All results, flags and the memory write strobe are registered on the clock edge that accepts the input. The reset is synchronous and active high.

Multi-word string instructions run as a sequence of single-word steps. The `chain_in` input marks every word after the first. On such a word the zero indication accumulates across the string, and a compare takes its borrow from the previous word's carry. Sub-opcode values that the unit does not implement are flagged as illegal and leave all state untouched.

Top module: `acc_lbm_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every accumulator, `flag_zero`, `flag_carry`, `flag_sign`, `xfer_zero`, `mem_we`, `mem_be` and `illegal_op` are cleared to 0.
- R2: Sub-opcodes 4'b0000, 4'b0001 and 4'b0010 write the operand OR, AND or XOR the selected accumulator back to that accumulator. They set `flag_zero` when the result is 0, set `flag_sign` to result bit 15, and clear `flag_carry`.
- R3: Sub-opcode 4'b0011 loads `{8'h00, operand[7:0]}` into the selected accumulator. It sets `flag_zero` from that value and clears `flag_sign` and `flag_carry`.
- R4: Sub-opcode 4'b0100 pulses `mem_we` for one cycle and registers `mem_waddr` equal to the address. `mem_wdata` holds accumulator bits [7:0] on both byte lanes. `mem_be` is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1; `mem_be` is 2'b00 whenever `mem_we` is low. The accumulators and the ALU flags are unchanged.
- R5: A byte store sets `xfer_zero` when the stored byte is 0. No other sub-opcode changes `xfer_zero`.
- R6: Sub-opcode 4'b0110 computes accumulator minus operand. It sets `flag_carry` when there is no borrow, `flag_zero` when the difference is 0, and `flag_sign` to difference bit 15. The accumulator is unchanged.
- R7: With `chain_in` high, the new zero flag (`flag_zero`, or `xfer_zero` for a store) is ANDed with its previous value. A chained compare subtracts an extra 1 when the previous `flag_carry` is 0.
- R8: Sub-opcode 4'b0101 and every value from 4'b0111 to 4'b1111 pulse `illegal_op` for one cycle. They change no accumulator and no flag, and do not raise `mem_we`.
- R9: A cycle with `in_valid` low changes no accumulator and no flag, and leaves `mem_we` and `illegal_op` low.
- R10: Only the accumulator named by `acc_sel` is written; all others keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| sub_op | input | 4 | Sub-opcode |
| acc_sel | input | ACC_SEL_W (1) | Accumulator select |
| chain_in | input | 1 | Continuation word of a string operation |
| opnd | input | DATA_W (16) | Data-memory operand |
| opnd_addr | input | ADDR_W (16) | Word address of the operand |
| acc_out | output | NUM_ACC*DATA_W (32) | All accumulators, accumulator 0 in the low bits |
| flag_zero | output | 1 | ALU zero flag |
| flag_carry | output | 1 | ALU carry / no-borrow flag |
| flag_sign | output | 1 | ALU sign flag |
| xfer_zero | output | 1 | Transfer status: last stored byte was zero |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Byte enables, bit 1 is the high byte |
| mem_wdata | output | DATA_W (16) | Write data, byte replicated on both lanes |
| mem_waddr | output | ADDR_W (16) | Write word address |
| illegal_op | output | 1 | Unimplemented sub-opcode seen |

## Verification
Some properties are checked by assertions on every cycle:

- the byte-enable encoding and its agreement with the address bit 0 that was written;
- lane replication of the write data;
- the absence of any state change on idle and illegal cycles;
- the accumulator being held across a compare.

The values themselves can only be shown by the bench's sweep, which runs every sub-opcode over both accumulators, a spread of operand patterns, both address parities and both chain settings. This covers:

- the logic results;
- the zero-filled byte load;
- the carry and borrow arithmetic of compares;
- the chained zero and borrow behaviour across string words.

// File: rtl/acc_lbm_pkg.sv
package acc_lbm_pkg;

  localparam logic [3:0] OP_OR  = 4'b0000;
  localparam logic [3:0] OP_AND = 4'b0001;
  localparam logic [3:0] OP_XOR = 4'b0010;
  localparam logic [3:0] OP_LDB = 4'b0011;
  localparam logic [3:0] OP_STB = 4'b0100;
  localparam logic [3:0] OP_CMP = 4'b0110;

  typedef struct packed {
    logic zero;
    logic carry;
    logic sign;
  } alu_flags_t;

endpackage

// File: rtl/acc_lbm_alu.sv
module acc_lbm_alu
  import acc_lbm_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [3:0]        op,
  input  logic              chain,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd,
  input  alu_flags_t        flags_in,
  input  logic              xz_in,
  output logic              acc_we,
  output logic [DATA_W-1:0] acc_res,
  output logic              flags_we,
  output alu_flags_t        flags_out,
  output logic              st_we,
  output logic              xz_out,
  output logic              illegal
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  logic              cin;
  logic [DATA_W:0]   diff_ext;
  logic              zero_keep;
  logic [DATA_W-1:0] res;

  // Borrow-in for a chained compare comes from the previous no-borrow flag.
  assign cin       = chain ? flags_in.carry : 1'b1;
  assign diff_ext  = {1'b0, acc_in} + {1'b0, ~opnd} + {{DATA_W{1'b0}}, cin};
  assign zero_keep = chain ? flags_in.zero : 1'b1;

  always_comb begin
    acc_we    = 1'b0;
    flags_we  = 1'b0;
    st_we     = 1'b0;
    illegal   = 1'b0;
    res       = '0;
    flags_out = flags_in;
    xz_out    = xz_in;
    case (op)
      OP_OR, OP_AND, OP_XOR, OP_LDB: begin
        case (op)
          OP_OR:   res = acc_in | opnd;
          OP_AND:  res = acc_in & opnd;
          OP_XOR:  res = acc_in ^ opnd;
          default: res = {{(DATA_W-BYTE_W){1'b0}}, opnd[BYTE_W-1:0]};
        endcase
        acc_we          = 1'b1;
        flags_we        = 1'b1;
        flags_out.zero  = (res == '0) & zero_keep;
        flags_out.carry = 1'b0;
        flags_out.sign  = res[DATA_W-1];
      end
      OP_CMP: begin
        flags_we        = 1'b1;
        flags_out.zero  = (diff_ext[DATA_W-1:0] == '0) & zero_keep;
        flags_out.carry = diff_ext[DATA_W];
        flags_out.sign  = diff_ext[DATA_W-1];
      end
      OP_STB: begin
        st_we  = 1'b1;
        xz_out = (acc_in[BYTE_W-1:0] == '0) & (chain ? xz_in : 1'b1);
      end
      default: illegal = 1'b1;
    endcase
  end

  assign acc_res = res;

  // R8: an illegal op requests no write of any kind.
  always_comb begin
    if (illegal) a_r8_illegal_no_write : assert (!acc_we && !flags_we && !st_we);
  end

endmodule

// File: rtl/acc_lbm_store.sv
module acc_lbm_store #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W/2-1:0] byte_in,
  input  logic                addr_lsb,
  output logic [1:0]          be,
  output logic [DATA_W-1:0]   wdata
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    assign wdata[ln*BYTE_W +: BYTE_W] = byte_in;
    assign be[ln] = (addr_lsb == ln[0]);
  end

endmodule

// File: rtl/acc_lbm_accfile.sv
module acc_lbm_accfile #(
  parameter int unsigned NUM_ACC   = 2,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ACC_SEL_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ACC_SEL_W-1:0]      sel,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_ACC*DATA_W-1:0] acc_flat
);

  logic [DATA_W-1:0] acc_q [NUM_ACC];

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)                               acc_q[i] <= '0;
      else if (we && (sel == ACC_SEL_W'(i))) acc_q[i] <= wdata;
    end
    assign acc_flat[i*DATA_W +: DATA_W] = acc_q[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_ACC; i++)
      if (sel == ACC_SEL_W'(i)) rdata = acc_q[i];
  end

endmodule

// File: rtl/acc_lbm_unit.sv
module acc_lbm_unit
  import acc_lbm_pkg::*;
#(
  parameter int unsigned NUM_ACC   = 2,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ACC_SEL_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [3:0]                sub_op,
  input  logic [ACC_SEL_W-1:0]      acc_sel,
  input  logic                      chain_in,
  input  logic [DATA_W-1:0]         opnd,
  input  logic [ADDR_W-1:0]         opnd_addr,
  output logic [NUM_ACC*DATA_W-1:0] acc_out,
  output logic                      flag_zero,
  output logic                      flag_carry,
  output logic                      flag_sign,
  output logic                      xfer_zero,
  output logic                      mem_we,
  output logic [1:0]                mem_be,
  output logic [DATA_W-1:0]         mem_wdata,
  output logic [ADDR_W-1:0]         mem_waddr,
  output logic                      illegal_op
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  alu_flags_t        flags_q, flags_d;
  logic              xz_q, xz_d;
  logic              acc_we, flags_we, st_we, illegal;
  logic [DATA_W-1:0] acc_rd, acc_res;
  logic [1:0]        be_c;
  logic [DATA_W-1:0] wdata_c;

  acc_lbm_accfile #(
    .NUM_ACC(NUM_ACC), .DATA_W(DATA_W), .ACC_SEL_W(ACC_SEL_W)
  ) u_accfile (
    .clk(clk), .rst(rst), .we(in_valid && acc_we), .sel(acc_sel),
    .wdata(acc_res), .rdata(acc_rd), .acc_flat(acc_out)
  );

  acc_lbm_alu #(.DATA_W(DATA_W)) u_alu (
    .op(sub_op), .chain(chain_in), .acc_in(acc_rd), .opnd(opnd),
    .flags_in(flags_q), .xz_in(xz_q), .acc_we(acc_we), .acc_res(acc_res),
    .flags_we(flags_we), .flags_out(flags_d), .st_we(st_we),
    .xz_out(xz_d), .illegal(illegal)
  );

  acc_lbm_store #(.DATA_W(DATA_W)) u_store (
    .byte_in(acc_rd[BYTE_W-1:0]), .addr_lsb(opnd_addr[0]),
    .be(be_c), .wdata(wdata_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= '0;
      xz_q       <= 1'b0;
      mem_we     <= 1'b0;
      mem_be     <= 2'b00;
      mem_wdata  <= '0;
      mem_waddr  <= '0;
      illegal_op <= 1'b0;
    end else begin
      mem_we     <= in_valid && st_we;
      mem_be     <= (in_valid && st_we) ? be_c : 2'b00;
      illegal_op <= in_valid && illegal;
      if (in_valid && flags_we) flags_q <= flags_d;
      if (in_valid && st_we) begin
        xz_q      <= xz_d;
        mem_wdata <= wdata_c;
        mem_waddr <= opnd_addr;
      end
    end
  end

  assign flag_zero  = flags_q.zero;
  assign flag_carry = flags_q.carry;
  assign flag_sign  = flags_q.sign;
  assign xfer_zero  = xz_q;

  // R4: byte-enable encoding and lane agreement
  a_r4_be_single : assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $countones(mem_be) == 1);
  a_r4_be_idle : assert property (@(posedge clk) disable iff (rst)
    !mem_we |-> mem_be == 2'b00);
  a_r4_lane_from_addr : assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_be[1] == mem_waddr[0]);
  a_r4_lanes_equal : assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata[DATA_W-1:BYTE_W] == mem_wdata[BYTE_W-1:0]);
  a_r4_store_keeps_acc : assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_op == OP_STB) |=> $stable(acc_out) && $stable(flags_q));
  // R3: a byte load never leaves sign or carry set
  a_r3_ldb_flags : assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_op == OP_LDB) |=> !flag_sign && !flag_carry);
  // R6: compare holds every accumulator
  a_r6_cmp_keeps_acc : assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_op == OP_CMP) |=> $stable(acc_out));
  // R8: illegal op has no side effect
  a_r8_no_side_effect : assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> !mem_we && $stable(acc_out) && $stable(flags_q) && $stable(xz_q));
  // R9: idle cycle is quiet
  a_r9_idle_quiet : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !mem_we && !illegal_op && $stable(acc_out) && $stable(flags_q));

endmodule

// File: tb/tb_acc_lbm_unit.sv
module tb_acc_lbm_unit;

  localparam int NA = 2;
  localparam int DW = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    sub_op = '0;
  logic [0:0]    acc_sel = '0;
  logic          chain_in = 1'b0;
  logic [DW-1:0] opnd = '0;
  logic [AW-1:0] opnd_addr = '0;
  logic [NA*DW-1:0] acc_out;
  logic flag_zero, flag_carry, flag_sign, xfer_zero, mem_we, illegal_op;
  logic [1:0]    mem_be;
  logic [DW-1:0] mem_wdata;
  logic [AW-1:0] mem_waddr;

  acc_lbm_unit #(.NUM_ACC(NA), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sub_op(sub_op),
    .acc_sel(acc_sel), .chain_in(chain_in), .opnd(opnd),
    .opnd_addr(opnd_addr), .acc_out(acc_out), .flag_zero(flag_zero),
    .flag_carry(flag_carry), .flag_sign(flag_sign), .xfer_zero(xfer_zero),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_waddr(mem_waddr), .illegal_op(illegal_op)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DW-1:0] m_acc [NA];
  logic m_z, m_c, m_s, m_xz, m_we, m_ill;
  logic [1:0]    m_be;
  logic [DW-1:0] m_wd;
  logic [AW-1:0] m_wa;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model(logic v, logic [3:0] op, int sel, logic [DW-1:0] d,
                       logic [AW-1:0] a, logic ch);
    logic [DW-1:0] r;
    logic [DW:0]   df;
    m_we = 0; m_ill = 0; m_be = 2'b00;
    if (!v) return;
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3: begin
        r = (op == 4'h0) ? (m_acc[sel] | d) : (op == 4'h1) ? (m_acc[sel] & d) :
            (op == 4'h2) ? (m_acc[sel] ^ d) : {8'h00, d[7:0]};
        m_acc[sel] = r;
        m_z = (r == 0) && (!ch || m_z);
        m_c = 0;
        m_s = r[15];
      end
      4'h6: begin
        df = {1'b0, m_acc[sel]} - {1'b0, d} - ((ch && !m_c) ? 17'd1 : 17'd0);
        m_c = !df[16];
        m_z = (df[15:0] == 0) && (!ch || m_z);
        m_s = df[15];
      end
      4'h4: begin
        m_we = 1;
        m_be = a[0] ? 2'b10 : 2'b01;
        m_wd = {m_acc[sel][7:0], m_acc[sel][7:0]};
        m_wa = a;
        m_xz = (m_acc[sel][7:0] == 0) && (!ch || m_xz);
      end
      default: m_ill = 1;
    endcase
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < NA; i++)
      chk((tag == "R9") ? "R9" : "R10", acc_out[i*DW +: DW], m_acc[i]);
    chk(tag, {29'd0, flag_zero, flag_carry, flag_sign}, {29'd0, m_z, m_c, m_s});
    chk((tag == "R4") ? "R5" : tag, xfer_zero, m_xz);
    chk(tag, {mem_we, mem_be, illegal_op}, {m_we, m_be, m_ill});
    if (m_we) begin
      chk("R4", mem_wdata, m_wd);
      chk("R4", mem_waddr, m_wa);
    end
  endtask

  task automatic apply(logic v, logic [3:0] op, int sel, logic [DW-1:0] d,
                       logic [AW-1:0] a, logic ch);
    string tag;
    in_valid = v; sub_op = op; acc_sel = sel[0]; opnd = d;
    opnd_addr = a; chain_in = ch;
    @(negedge clk);
    model(v, op, sel, d, a, ch);
    if (!v) tag = "R9";
    else if (ch) tag = "R7";
    else case (op)
      4'h0, 4'h1, 4'h2: tag = "R2";
      4'h3: tag = "R3";
      4'h4: tag = "R4";
      4'h6: tag = "R6";
      default: tag = "R8";
    endcase
    compare(tag);
  endtask

  logic [DW-1:0] pats [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h00FF,
                              16'hFF00, 16'h5A3C, 16'h0001, 16'hA5C3};

  initial begin
    for (int i = 0; i < NA; i++) m_acc[i] = '0;
    {m_z, m_c, m_s, m_xz, m_we, m_ill, m_be} = '0;
    m_wd = '0; m_wa = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");
    // seed accumulators with non-trivial values
    apply(1, 4'h0, 0, 16'h12F0, 0, 0);
    apply(1, 4'h0, 1, 16'h8001, 0, 0);
    for (int op = 0; op < 16; op++)
      for (int s = 0; s < NA; s++)
        for (int p = 0; p < 8; p++)
          for (int k = 0; k < 4; k++) begin
            apply(1, op[3:0], s, pats[p] ^ {8'h00, 4'(k), 4'(op)},
                  16'h0100 + 16'(k), k[1]);
            if (op == 3 && p == 5) apply(1, 4'h0, s, 16'h7777, 0, 0);
            if (p == 3) apply(0, op[3:0], s, 16'hFFFF, 1, 0);
          end
    // compare corners: equal, borrow, chained borrow
    apply(1, 4'h3, 0, 16'h0005, 0, 0);
    apply(1, 4'h6, 0, 16'h0005, 0, 0);
    apply(1, 4'h6, 0, 16'h0006, 0, 0);
    apply(1, 4'h6, 0, 16'h0004, 0, 1);
    apply(1, 4'h6, 0, 16'h0005, 0, 1);
    // chained store zero across a string
    apply(1, 4'h3, 1, 16'hAB00, 0, 0);
    apply(1, 4'h4, 1, 0, 16'h0002, 0);
    apply(1, 4'h3, 1, 16'h0009, 0, 0);
    apply(1, 4'h4, 1, 0, 16'h0003, 1);
    // reset again mid-run
    rst = 1'b1; in_valid = 0;
    @(negedge clk);
    for (int i = 0; i < NA; i++) m_acc[i] = '0;
    {m_z, m_c, m_s, m_xz, m_we, m_ill, m_be} = '0;
    rst = 1'b0;
    compare("R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule